// File: doc/BRIEF.md
# Signed Add-Shift Multiplier

This block forms the signed product of two small two's complement operands. It works one multiplier bit at a time. A controller walks through the multiplier from its least significant bit upward. For each set bit it adds the multiplicand into the upper half of an accumulator, and every bit position ends with an arithmetic right shift of the whole accumulator. The multiplier's sign bit carries negative weight, so when that bit is set the multiplicand is subtracted instead of added. The subtraction uses the same adder: the multiplicand is inverted and the carry-in is set. The adder is one bit wider than the operands, so a partial sum never loses its sign.

The caller holds the operands and pulses `start_i` while the block is idle. It then waits for the one-cycle `done_o` pulse and reads `product_o`, which holds its value until the next accepted start. With `frac_i` high at the start, both operands are read as signed fractions with three fraction bits. The result is then given with seven fraction bits. The one product that cannot be represented in that form saturates to the largest positive code.

Top module: `smul_seq`

## Requirements
- R1: While reset is held and directly after it is released, `done_o` is 0 and `product_o` is 0.
- R2: With `frac_i`=0 at start, `product_o` at the `done_o` pulse equals the signed 8-bit product of `mcand_i` and `mplier_i`, each read as a 4-bit two's complement value, for every operand pair.
- R3: (-8) x (-8) in integer mode gives +64 (8'h40).
- R4: A set multiplier sign bit subtracts the multiplicand: 3 x (-1) gives -3 (8'hFD) and (-8) x (-1) gives +8 (8'h08).
- R5: `done_o` rises 4 + k clock edges after the edge that samples the start, where k is the number of 1 bits in the multiplier. Each set bit costs an add cycle followed by a shift cycle, and each clear bit costs a single shift cycle.
- R6: `done_o` is high for exactly one cycle. `product_o` then holds its value while the block idles.
- R7: A start pulse while an operation is running is ignored: the result and the latency are those of the operation already running.
- R8: With `frac_i`=1 at start, `product_o` is the integer product shifted left by one bit with a 0 in bit 0.
- R9: In fraction mode, (-1.0) x (-1.0) (both operands 4'h8) saturates to 8'h7F.
- R10: The operands and `frac_i` are sampled only at the accepted start. Changing them during an operation does not alter the result.

Assertion labels use the AST_ prefix and carry these requirement tags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted only while idle |
| frac_i | input | 1 | 1 = operands are signed fractions, 0 = signed integers |
| mcand_i | input | W (4) | Multiplicand, two's complement |
| mplier_i | input | W (4) | Multiplier, two's complement |
| product_o | output | 2W (8) | Signed product, valid from the `done_o` pulse until the next start |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that reset is applied before the first start and that the start strobe is a plain synchronous level. They do not require it to be a single-cycle pulse, because the controller only acts on it while idle. They also assume the operand inputs are settled at the sampling edge. The bench changes every input at the falling edge, so each value is stable well before the rising edge that samples it. The bench also drives a stray start with altered operands in the middle of a run, so the assertions on the held multiplicand and the shift counter see that case.

// File: rtl/smul_pkg.sv
package smul_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TEST  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_DONE  = 2'd3
  } state_e;

  // controller commands to the datapath
  typedef struct packed {
    logic ld;  // load operands, clear upper accumulator
    logic ad;  // write adder result into upper accumulator
    logic sh;  // arithmetic right shift of accumulator
    logic cm;  // complement multiplicand (subtract)
  } ctl_t;

endpackage

// File: rtl/smul_addsub.sv
module smul_addsub #(
  parameter int N = 5
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic         sub_i,
  output logic [N-1:0] sum_o
);

  logic [N-1:0] b_eff;
  logic [N:0]   full;

  assign b_eff = sub_i ? ~b_i : b_i;
  assign full  = {1'b0, a_i} + {1'b0, b_eff} + {{N{1'b0}}, sub_i};
  assign sum_o = full[N-1:0];  // carry out dropped

endmodule

// File: rtl/smul_ctrl.sv
module smul_ctrl
  import smul_pkg::*;
#(
  parameter int W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic lsb_i,
  output ctl_t ctl_o,
  output logic done_o
);

  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W - 1);
  localparam logic [CW-1:0] FULL = CW'(W);

  state_e        state_q, state_d;
  logic [CW-1:0] cnt_q;
  logic          last;

  assign last = (cnt_q == LAST);

  always_comb begin
    state_d = state_q;
    ctl_o   = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          ctl_o.ld = 1'b1;
          state_d  = ST_TEST;
        end
      end
      ST_TEST: begin
        if (lsb_i) begin
          ctl_o.ad = 1'b1;
          ctl_o.cm = last;  // sign bit carries negative weight
          state_d  = ST_SHIFT;
        end else begin
          ctl_o.sh = 1'b1;
          state_d  = last ? ST_DONE : ST_TEST;
        end
      end
      ST_SHIFT: begin
        ctl_o.sh = 1'b1;
        state_d  = last ? ST_DONE : ST_TEST;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (ctl_o.ld)      cnt_q <= '0;
      else if (ctl_o.sh) cnt_q <= cnt_q + CW'(1);
    end
  end

  assign done_o = (state_q == ST_DONE);

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R6

  AST_DONE_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (state_q == ST_IDLE));  // R6

  AST_SHIFT_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cnt_q == FULL));  // R5

  AST_ADD_THEN_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_o.ad |=> ctl_o.sh);  // R5

  AST_SUB_ON_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_o.cm |-> (ctl_o.ad && cnt_q == LAST));  // R4

endmodule

// File: rtl/smul_datapath.sv
module smul_datapath
  import smul_pkg::*;
#(
  parameter int W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  ctl_t            ctl_i,
  input  logic [W-1:0]    mcand_i,
  input  logic [W-1:0]    mplier_i,
  output logic [2*W-1:0]  prod_o,
  output logic            lsb_o
);

  localparam int AW = 2 * W + 1;  // accumulator width
  localparam int UW = W + 1;      // adder / upper field width

  logic [AW-1:0] acc_q;
  logic [W-1:0]  mcand_q;
  logic [UW-1:0] sum;

  smul_addsub #(.N(UW)) u_addsub (
    .a_i   (acc_q[AW-1:W]),
    .b_i   ({mcand_q[W-1], mcand_q}),
    .sub_i (ctl_i.cm),
    .sum_o (sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      mcand_q <= '0;
    end else if (ctl_i.ld) begin
      acc_q   <= {{UW{1'b0}}, mplier_i};
      mcand_q <= mcand_i;
    end else if (ctl_i.ad) begin
      acc_q   <= {sum, acc_q[W-1:0]};
    end else if (ctl_i.sh) begin
      acc_q   <= {acc_q[AW-1], acc_q[AW-1:1]};
    end
  end

  assign prod_o = acc_q[2*W-1:0];
  assign lsb_o  = acc_q[0];

  AST_LOAD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_i.ld |=> (acc_q[AW-1:W] == '0));  // R10

  AST_MCAND_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_i.ld |=> $stable(mcand_q));  // R7

  AST_SIGN_EXTENDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_i.sh |=> (acc_q[AW-1] == acc_q[AW-2]));  // R2

endmodule

// File: rtl/smul_outfmt.sv
module smul_outfmt #(
  parameter int W = 4
) (
  input  logic [2*W-1:0] raw_i,
  input  logic           frac_i,
  output logic [2*W-1:0] prod_o
);

  localparam int PW = 2 * W;
  localparam logic [PW-1:0] OVF = PW'(1) << (PW - 2);  // (-1.0)*(-1.0)
  localparam logic [PW-1:0] MAX = {1'b0, {(PW - 1){1'b1}}};

  always_comb begin
    if (!frac_i)           prod_o = raw_i;
    else if (raw_i == OVF) prod_o = MAX;
    else                   prod_o = {raw_i[PW-2:0], 1'b0};
  end

endmodule

// File: rtl/smul_seq.sv
module smul_seq
  import smul_pkg::*;
#(
  parameter int W = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           frac_i,
  input  logic [W-1:0]   mcand_i,
  input  logic [W-1:0]   mplier_i,
  output logic [2*W-1:0] product_o,
  output logic           done_o
);

  ctl_t           ctl;
  logic           lsb;
  logic           frac_q;
  logic [2*W-1:0] raw;

  smul_ctrl #(.W(W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .lsb_i   (lsb),
    .ctl_o   (ctl),
    .done_o  (done_o)
  );

  smul_datapath #(.W(W)) u_dp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ctl_i    (ctl),
    .mcand_i  (mcand_i),
    .mplier_i (mplier_i),
    .prod_o   (raw),
    .lsb_o    (lsb)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     frac_q <= 1'b0;
    else if (ctl.ld) frac_q <= frac_i;
  end

  smul_outfmt #(.W(W)) u_fmt (
    .raw_i  (raw),
    .frac_i (frac_q),
    .prod_o (product_o)
  );

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> $stable(product_o));  // R6

  AST_FRAC_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl.ld |=> $stable(frac_q));  // R10

endmodule

// File: tb/smul_seq_test.sv
module smul_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic         frac_i = 1'b0;
  logic [W-1:0] mcand_i = '0;
  logic [W-1:0] mplier_i = '0;
  logic [7:0]   product_o;
  logic         done_o;

  int vectors = 0;
  int errors  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  smul_seq #(.W(W)) uut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .start_i   (start_i),
    .frac_i    (frac_i),
    .mcand_i   (mcand_i),
    .mplier_i  (mplier_i),
    .product_o (product_o),
    .done_o    (done_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] int_prod(input logic [3:0] a, input logic [3:0] b);
    int p;
    p = int'($signed(a)) * int'($signed(b));
    return 8'(p);
  endfunction

  function automatic logic [7:0] frac_prod(input logic [3:0] a, input logic [3:0] b);
    if (a == 4'h8 && b == 4'h8) return 8'h7F;
    return {int_prod(a, b)[6:0], 1'b0};
  endfunction

  // one operation; optional stray start with altered inputs mid-run
  task automatic run_op(input logic [3:0] a, input logic [3:0] b, input logic frac,
                        input logic disturb, output logic [7:0] prod, output int lat);
    @(negedge clk);
    mcand_i = a; mplier_i = b; frac_i = frac; start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    lat = 0;
    while (!done_o && lat < 64) begin
      if (disturb && lat == 1) begin
        start_i = 1'b1; mcand_i = ~a; mplier_i = ~b; frac_i = ~frac;
      end else begin
        start_i = 1'b0;
      end
      @(posedge clk);
      @(negedge clk);
      lat++;
    end
    start_i = 1'b0;
    prod = product_o;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 done in reset", int'(done_o), 0);
    check("R1 product in reset", int'(product_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 done after reset", int'(done_o), 0);
    check("R1 product after reset", int'(product_o), 0);
  endtask

  task automatic t_exhaustive();
    logic [7:0] p;
    int lat;
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        run_op(4'(i), 4'(j), 1'b0, 1'b0, p, lat);
        check($sformatf("R2 %0d*%0d", i, j), int'(p), int'(int_prod(4'(i), 4'(j))));
        check($sformatf("R5 latency mplier %0h", j), lat, 4 + $countones(4'(j)));
      end
    end
  endtask

  task automatic t_corners();
    logic [7:0] p;
    int lat;
    run_op(4'h8, 4'h8, 1'b0, 1'b0, p, lat);
    check("R3 -8*-8", int'(p), 8'h40);
    run_op(4'h3, 4'hF, 1'b0, 1'b0, p, lat);
    check("R4 3*-1", int'(p), 8'hFD);
    run_op(4'h8, 4'hF, 1'b0, 1'b0, p, lat);
    check("R4 -8*-1", int'(p), 8'h08);
    check("R5 latency all ones", lat, 8);
  endtask

  task automatic t_done_hold();
    logic [7:0] p;
    int lat;
    run_op(4'h5, 4'hA, 1'b0, 1'b0, p, lat);
    @(negedge clk);
    check("R6 done one cycle", int'(done_o), 0);
    check("R6 product held", int'(product_o), int'(p));
    repeat (3) @(negedge clk);
    check("R6 product held idle", int'(product_o), 8'hE2);
    check("R6 done stays low", int'(done_o), 0);
  endtask

  task automatic t_busy_start();
    logic [7:0] p;
    int lat;
    run_op(4'h6, 4'h5, 1'b0, 1'b1, p, lat);
    check("R7 stray start result", int'(p), 8'h1E);
    check("R7 stray start latency", lat, 6);
    run_op(4'h9, 4'h3, 1'b1, 1'b1, p, lat);
    check("R10 inputs changed mid-run", int'(p), int'(frac_prod(4'h9, 4'h3)));
  endtask

  task automatic t_frac();
    logic [7:0] p;
    int lat;
    run_op(4'h4, 4'h4, 1'b1, 1'b0, p, lat);
    check("R8 0.5*0.5", int'(p), 8'h20);
    run_op(4'hC, 4'h6, 1'b1, 1'b0, p, lat);
    check("R8 -0.5*0.75", int'(p), int'(frac_prod(4'hC, 4'h6)));
    run_op(4'h8, 4'h8, 1'b1, 1'b0, p, lat);
    check("R9 -1*-1 saturates", int'(p), 8'h7F);
    run_op(4'h8, 4'h7, 1'b1, 1'b0, p, lat);
    check("R8 -1*0.875", int'(p), 8'h90);
    run_op(4'h8, 4'h8, 1'b0, 1'b0, p, lat);
    check("R8 mode back to integer", int'(p), 8'h40);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_exhaustive();
    t_corners();
    t_done_hold();
    t_busy_start();
    t_frac();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule